// File: doc/BRIEF.md
# Peripheral Soft-Reset Handshake Sequencer

This block runs the enable or full-reset handshake on one peripheral's control register without software involvement. On a start pulse it works through a series of read-modify-write and polling steps on a simple register port. It uses two bits of that register. The most significant bit is the soft-reset request. The bit below it is the clock-gate bit. Every poll is bounded. If a poll runs out, the attempt is abandoned and the whole sequence starts again from the first step, up to a set number of attempts.

The sequence always releases soft reset first and waits for the release to show on the bus. It then removes clock gating. In full-reset mode it next re-asserts soft reset, waits until the peripheral reports itself gated, releases reset again and ungates once more. Both modes finish by waiting until the gate bit reads clear. A one-cycle done pulse reports the outcome of the final attempt, together with an error code that names the step that timed out.

Top module: `soft_reset_seq`

## Requirements
- R1: After reset, done_o, err_o, err_code_o, bus_re_o and bus_we_o are all 0.
- R2: Bit DW-1 of the control register is soft reset and bit DW-2 is clock gate. Every write copies bits DW-3:0 unchanged from the read that came just before it.
- R3: In full mode (just_enable_i=0) a clean run makes 5 writes. The order is: clear reset, clear gate, set reset, clear reset, clear gate. The run ends with a done pulse, err_code_o=0, and both control bits reading 0.
- R4: In just-enable mode (just_enable_i=1) no write sets the reset bit. A clean run makes exactly 2 writes: clear reset, then clear gate.
- R5: A bus request (bus_re_o or bus_we_o) is held with stable address and write data until a cycle with bus_ready_i=1. The two strobes are never high together, and bus_addr_o always equals CTRL_ADDR.
- R6: Each poll makes at most POLL_LIMIT reads. A condition first met on read POLL_LIMIT still succeeds. A condition that is not met by read POLL_LIMIT fails the attempt.
- R7: The error code names the failing poll as follows. 1 means reset did not release. 2 means the gate bit never rose after reset was re-asserted. 3 means reset did not release after the re-reset. 4 means the gate bit did not clear at the end.
- R8: A failed attempt restarts from the first step, with at most MAX_TRIES attempts in all. A persistent fault in the first poll therefore costs exactly MAX_TRIES*(1+POLL_LIMIT) reads.
- R9: Only the last attempt's outcome is reported. done_o is high for exactly one cycle. err_code_o holds its value until the next accepted start, which clears it.
- R10: A start pulse that arrives while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; taken only when idle |
| just_enable_i | input | 1 | 1 skips the re-reset phase; sampled at start |
| bus_addr_o | output | AW | Control register address |
| bus_wdata_o | output | DW | Write data |
| bus_we_o | output | 1 | Write strobe |
| bus_re_o | output | 1 | Read strobe |
| bus_rdata_i | input | DW | Read data, valid when bus_ready_i is high |
| bus_ready_i | input | 1 | Transfer completes in this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last run failed |
| err_code_o | output | 3 | Failing step code, 0 when clean |

## Verification
The assertions assume a bus slave that returns read data in the same cycle as bus_ready_i, and that completes one transfer for each ready cycle. They also assume that start_i may arrive at any time, including mid-run. The bench slave raises ready at random, only while a strobe is high. It models the gate bit rising when reset is set, along with stuck bits and delayed releases. A second start is also issued deliberately during a long failing run.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [2:0] {
    OP_REL1, OP_UNGATE1, OP_ASSERT, OP_REL2, OP_UNGATE2, OP_SETTLE
  } op_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_ENABLE   = 3'd1,
    ERR_RESET    = 3'd2,
    ERR_REENABLE = 3'd3,
    ERR_UNGATE   = 3'd4
  } err_e;

  typedef struct packed {
    logic rmw;       // step starts with a read-modify-write
    logic tgt_sr;    // 1: modify reset bit, 0: gate bit
    logic tgt_val;
    logic poll;      // step ends with a bounded poll
    logic poll_sr;   // 1: watch reset bit, 0: gate bit
    logic poll_val;
    err_e err;
  } step_t;
endpackage

// File: rtl/srs_bound_ctr.sv
module srs_bound_ctr #(
  parameter int unsigned LIMIT = 4,
  localparam int unsigned W = $clog2(LIMIT + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end

  assign last_o = (cnt_o == LAST);
endmodule

// File: rtl/srs_step_decode.sv
module srs_step_decode
  import srs_pkg::*;
(
  input  op_e   op_i,
  input  logic  just_i,
  output step_t step_o,
  output op_e   next_o,
  output logic  final_o
);
  always_comb begin
    step_o  = '{rmw: 1'b1, tgt_sr: 1'b1, tgt_val: 1'b0, poll: 1'b0,
                poll_sr: 1'b1, poll_val: 1'b0, err: ERR_NONE};
    next_o  = OP_SETTLE;
    final_o = 1'b0;
    unique case (op_i)
      OP_REL1: begin
        step_o.poll = 1'b1;
        step_o.err  = ERR_ENABLE;
        next_o      = OP_UNGATE1;
      end
      OP_UNGATE1: begin
        step_o.tgt_sr = 1'b0;
        next_o        = just_i ? OP_SETTLE : OP_ASSERT;
      end
      OP_ASSERT: begin
        step_o.tgt_val  = 1'b1;
        step_o.poll     = 1'b1;
        step_o.poll_sr  = 1'b0;
        step_o.poll_val = 1'b1;
        step_o.err      = ERR_RESET;
        next_o          = OP_REL2;
      end
      OP_REL2: begin
        step_o.poll = 1'b1;
        step_o.err  = ERR_REENABLE;
        next_o      = OP_UNGATE2;
      end
      OP_UNGATE2: begin
        step_o.tgt_sr = 1'b0;
        next_o        = OP_SETTLE;
      end
      OP_SETTLE: begin
        step_o.rmw     = 1'b0;
        step_o.poll    = 1'b1;
        step_o.poll_sr = 1'b0;
        step_o.err     = ERR_UNGATE;
        final_o        = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/soft_reset_seq.sv
module soft_reset_seq
  import srs_pkg::*;
#(
  parameter int unsigned     DW         = 32,
  parameter int unsigned     AW         = 12,
  parameter logic [AW-1:0]   CTRL_ADDR  = '0,
  parameter int unsigned     POLL_LIMIT = 1000000,
  parameter int unsigned     MAX_TRIES  = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          just_enable_i,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  output logic          bus_we_o,
  output logic          bus_re_o,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_ready_i,
  output logic          done_o,
  output logic          err_o,
  output logic [2:0]    err_code_o
);
  localparam int unsigned SR_POS = DW - 1;
  localparam int unsigned CG_POS = DW - 2;
  localparam int unsigned PW = $clog2(POLL_LIMIT + 1);
  localparam int unsigned TW = $clog2(MAX_TRIES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_POLL} st_e;

  st_e           st_q;
  op_e           op_q, nxt_op;
  logic          mode_q;
  logic [DW-1:0] wdata_q, patched;
  logic          done_q;
  err_e          err_q;
  step_t         step;
  logic          fin, hit, fail, go;
  logic [PW-1:0] poll_cnt;
  logic [TW-1:0] try_cnt;
  logic          poll_last, try_last;

  srs_step_decode u_dec (
    .op_i(op_q), .just_i(mode_q), .step_o(step), .next_o(nxt_op), .final_o(fin)
  );

  srs_bound_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk_i, .rst_ni,
    .clr_i (st_q != ST_POLL),
    .inc_i (st_q == ST_POLL && bus_ready_i && !hit && !poll_last),
    .cnt_o (poll_cnt),
    .last_o(poll_last)
  );

  srs_bound_ctr #(.LIMIT(MAX_TRIES)) u_try (
    .clk_i, .rst_ni,
    .clr_i (st_q == ST_IDLE),
    .inc_i (fail && !try_last),
    .cnt_o (try_cnt),
    .last_o(try_last)
  );

  assign hit  = (step.poll_sr ? bus_rdata_i[SR_POS] : bus_rdata_i[CG_POS]) == step.poll_val;
  assign fail = (st_q == ST_POLL) && bus_ready_i && !hit && poll_last;
  assign go   = bus_ready_i && (((st_q == ST_WR) && !step.poll) || ((st_q == ST_POLL) && hit));

  always_comb begin
    patched = bus_rdata_i;
    if (step.tgt_sr) patched[SR_POS] = step.tgt_val;
    else             patched[CG_POS] = step.tgt_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_REL1;
      mode_q  <= 1'b0;
      wdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= ERR_NONE;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          mode_q <= just_enable_i;
          op_q   <= OP_REL1;
          err_q  <= ERR_NONE;
          st_q   <= ST_RD;
        end
        ST_RD: if (bus_ready_i) begin
          wdata_q <= patched;
          st_q    <= ST_WR;
        end
        ST_WR: if (bus_ready_i && step.poll) st_q <= ST_POLL;
        ST_POLL: ;
        default: st_q <= ST_IDLE;
      endcase
      if (go) begin
        if (fin) begin
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end else begin
          op_q <= nxt_op;
          st_q <= (nxt_op == OP_SETTLE) ? ST_POLL : ST_RD;
        end
      end else if (fail) begin
        if (try_last) begin
          done_q <= 1'b1;
          err_q  <= step.err;
          st_q   <= ST_IDLE;
        end else begin
          op_q <= OP_REL1;
          st_q <= ST_RD;
        end
      end
    end
  end

  assign bus_addr_o  = CTRL_ADDR;
  assign bus_wdata_o = wdata_q;
  assign bus_re_o    = (st_q == ST_RD) || (st_q == ST_POLL);
  assign bus_we_o    = (st_q == ST_WR);
  assign done_o      = done_q;
  assign err_code_o  = err_q;
  assign err_o       = (err_q != ERR_NONE);
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 12,
  parameter int unsigned PW    = 4,
  parameter int unsigned TW    = 4,
  parameter int unsigned LIMIT = 8,
  parameter int unsigned TRIES = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          re,
  input logic          we,
  input logic          ready,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] rdata,
  input logic [DW-1:0] wdata,
  input logic          done,
  input logic [2:0]    err_code,
  input logic          mode_q,
  input logic [PW-1:0] poll_cnt,
  input logic [TW-1:0] try_cnt
);
  logic [DW-1:0] last_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          last_rd <= '0;
    else if (re && ready) last_rd <= rdata;
  end

  a_r5_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({re, we}));
  a_r5_hold_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re && !ready |=> re && $stable(addr));
  a_r5_hold_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we && !ready |=> we && $stable(wdata));
  a_r2_keep_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> wdata[DW-3:0] == last_rd[DW-3:0]);
  a_r4_no_rereset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q && we |-> !wdata[DW-1]);
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !done);
  a_r9_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_code != $past(err_code)) |-> (done || $past(start_i)));
  a_r3_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !re && !we);
  a_r6_poll_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(poll_cnt) < LIMIT);
  a_r8_try_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(try_cnt) < TRIES);
endmodule

bind soft_reset_seq srs_checker #(
  .DW(DW), .AW(AW), .PW(PW), .TW(TW), .LIMIT(POLL_LIMIT), .TRIES(MAX_TRIES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
  .re(bus_re_o), .we(bus_we_o), .ready(bus_ready_i), .addr(bus_addr_o),
  .rdata(bus_rdata_i), .wdata(bus_wdata_o), .done(done_o), .err_code(err_code_o),
  .mode_q(mode_q), .poll_cnt(poll_cnt), .try_cnt(try_cnt)
);

// File: tb/soft_reset_seq_test.sv
module soft_reset_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 12;
  localparam logic [AW-1:0] ADDR = 12'h3a4;
  localparam int L = 8;
  localparam int T = 3;

  // fault kinds
  localparam int K_NONE = 0, K_STUCK_SR = 1, K_NO_GATE = 2, K_STUCK_CG = 3,
                 K_SLOW_ALL = 4, K_SLOW_AFTER = 5, K_SLOW_ONCE = 6;

  logic clk = 0, rst_n = 0, start = 0, just = 0;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata = '0;
  logic we, re, ready = 0, done, err;
  logic [2:0] code;

  int checks = 0, errors = 0;
  int kind = 0, dly_set = 0, rdyp = 100;
  logic [DW-1:0] val;
  int dly = 0, reads = 0, writes = 0, set_writes = 0, dones = 0;
  bit armed = 0, once_used = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  soft_reset_seq #(.DW(DW), .AW(AW), .CTRL_ADDR(ADDR), .POLL_LIMIT(L), .MAX_TRIES(T)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .just_enable_i(just),
    .bus_addr_o(addr), .bus_wdata_o(wdata), .bus_we_o(we), .bus_re_o(re),
    .bus_rdata_i(rdata), .bus_ready_i(ready), .done_o(done), .err_o(err), .err_code_o(code)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_code(int k, int d, bit j);
    case (k)
      K_STUCK_SR:   return 1;
      K_NO_GATE:    return j ? 0 : 2;
      K_STUCK_CG:   return 4;
      K_SLOW_ALL:   return (d >= L) ? 1 : 0;
      K_SLOW_AFTER: return (!j && d >= L) ? 3 : 0;
      K_SLOW_ONCE:  return (!j && d >= L && T < 2) ? 3 : 0;
      default:      return 0;
    endcase
  endfunction

  // peripheral register model
  initial begin
    forever begin
      @(negedge clk);
      ready = 0;
      if (re || we) begin
        if ($urandom_range(0, 99) < rdyp) begin
          ready = 1;
          chk(addr == ADDR, "R5", "address", int'(addr), int'(ADDR));
          if (re) begin
            logic [DW-1:0] r;
            r = val;
            if (dly > 0) begin r[DW-1] = 1'b1; dly--; end
            if (kind == K_STUCK_SR) r[DW-1] = 1'b1;
            if (kind == K_STUCK_CG) r[DW-2] = 1'b1;
            rdata = r;
            reads++;
          end else begin
            writes++;
            val = wdata;
            if (wdata[DW-1]) begin
              set_writes++;
              if (kind != K_NO_GATE) val[DW-2] = 1'b1;
              armed = (kind == K_SLOW_AFTER) || (kind == K_SLOW_ONCE && !once_used);
              if (kind == K_SLOW_ONCE) once_used = 1;
            end else begin
              dly = (kind == K_SLOW_ALL || armed) ? dly_set : 0;
              armed = 0;
            end
          end
        end
      end
    end
  end

  always @(negedge clk) if (done) dones++;

  task automatic run(int k, int d, bit j, logic [DW-3:0] low, int rp, bit mid_start, string tag);
    int cyc;
    int ec;
    bit prev_err;
    kind = k; dly_set = d; rdyp = rp;
    val = {2'b11, low}; dly = 0; armed = 0; once_used = 0;
    reads = 0; writes = 0; set_writes = 0; dones = 0;
    prev_err = err;
    ec = exp_code(k, d, j);
    @(negedge clk);
    just = j; start = 1;
    @(negedge clk);
    start = 0;
    if (prev_err) chk(err == 0, "R9", {tag, " err cleared by start"}, int'(err), 0);
    cyc = 0;
    while (!done && cyc < 5000) begin
      if (mid_start && cyc == 20) start = 1;
      @(negedge clk);
      start = 0;
      cyc++;
    end
    if (cyc >= 5000) begin
      chk(0, "R3", {tag, " watchdog"}, cyc, 0);
      return;
    end
    chk(int'(code) == ec, "R7", {tag, " code"}, int'(code), ec);
    chk(err == (ec != 0), "R7", {tag, " err flag"}, int'(err), int'(ec != 0));
    @(negedge clk);
    chk(done == 0, "R9", {tag, " done one cycle"}, int'(done), 0);
    repeat (3) @(negedge clk);
    chk(int'(code) == ec, "R9", {tag, " code held"}, int'(code), ec);
    chk(dones == 1, "R10", {tag, " single done"}, dones, 1);
    if (ec == 0 && k != K_STUCK_CG) begin
      chk(val[DW-3:0] == low, "R2", {tag, " low bits kept"}, int'(val[DW-3:0]), int'(low));
      chk(val[DW-1:DW-2] == 2'b00, "R3", {tag, " control bits clear"}, int'(val[DW-1:DW-2]), 0);
    end
    if (j) chk(set_writes == 0, "R4", {tag, " no re-reset"}, set_writes, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    val = '0;
    #(3*CLK_PERIOD) rst_n = 1;
    @(negedge clk);
    chk(done == 0 && err == 0, "R1", "done/err after reset", int'({done, err}), 0);
    chk(code == 0, "R1", "code after reset", int'(code), 0);
    chk(!re && !we, "R1", "bus idle after reset", int'({re, we}), 0);

    run(K_NONE, 0, 0, 30'h1234567, 100, 0, "full clean");
    chk(writes == 5, "R3", "full writes", writes, 5);
    chk(set_writes == 1, "R3", "full set writes", set_writes, 1);
    run(K_NONE, 0, 1, 30'h2aaa5555, 50, 0, "just clean");
    chk(writes == 2, "R4", "just writes", writes, 2);
    run(K_SLOW_ALL, L-1, 1, 30'h0f0f0f0, 100, 0, "R6 limit-1");
    run(K_SLOW_ALL, L, 1, 30'h0f0f0f0, 100, 0, "R6 limit");
    chk(reads == T*(1+L), "R8", "reads on persistent fault", reads, T*(1+L));
    run(K_NONE, 0, 0, 30'h3ffffff, 100, 0, "clean after error");
    run(K_STUCK_SR, 0, 0, 30'h11, 60, 1, "R10 mid start");
    chk(reads == T*(1+L), "R10", "reads with ignored start", reads, T*(1+L));
    run(K_NO_GATE, 0, 0, 30'h22, 100, 0, "R7 reset step");
    run(K_SLOW_AFTER, L+2, 0, 30'h33, 100, 0, "R7 re-enable step");
    run(K_STUCK_CG, 0, 0, 30'h44, 100, 0, "R7 ungate step");
    run(K_SLOW_ONCE, L+2, 0, 30'h55, 100, 0, "R8 recover");
    chk(set_writes == 2, "R8", "second attempt ran", set_writes, 2);

    for (int i = 0; i < 20; i++) begin
      int k, d;
      k = $urandom_range(0, 6);
      d = $urandom_range(0, L + 2);
      run(k, d, 1'($urandom_range(0, 1)), 30'($urandom), $urandom_range(30, 100), 0, "random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule